// File: doc/BRIEF.md
# One-Shot / Free-Running Timer Controller

This block is an up-counter governed by a small control register. Software, through a simple write/read bus, enables the timer and asks for either a one-shot run (one full period, then halt) or a free-running run (wrap forever). A 2-bit trigger selector decides whether that request acts at once (selector `00`) or is held armed until an external trigger pulse. The mode can be changed while the counter is running.

Each time the count meets the reload value, the counter wraps to zero and raises a one-cycle update pulse. It also sets a DMA request line, which stays high until the timer is disabled. Software can clear the counter in two ways. One is a counter-clear command that takes effect after a fixed three-cycle delay, standing in for a clock-domain crossing. The other is a clear-on-read option that zeroes the counter after each read of the count register.

Top module: `tmr_mode_ctl`

## Requirements
- R1: After reset the count is 0, the update pulse and DMA request are low, and the control register reads 0.
- R2: While running, the count rises by one per clock from 0. On the edge where it equals the reload value it returns to 0 and the update pulse is high for exactly one cycle.
- R3: With selector `00`, writing control bit 1 (one-shot start) while enabled starts counting on the next edge. After one full period the counter stops at 0.
- R4: With selector `00`, writing control bit 2 (free-run start) while enabled starts counting. The counter keeps wrapping and pulses the update output at every wrap.
- R5: With a non-zero selector, a start write only arms the timer. The armed start reads back as 1 in bit 1 (one-shot) or bit 2 (free-run). Counting begins at the first clock edge that samples the trigger input high, and the armed bit then reads 0.
- R6: A one-shot start written during a free-running run makes the counter stop at the next wrap.
- R7: A free-run start written during a one-shot run cancels the stop, and counting continues past the wrap.
- R8: Writing control bit 3 (counter clear) while enabled makes bit 3 read 1. The count becomes 0 on the third clock edge after the write edge, and bit 3 then reads 0.
- R9: A counter-clear write made while bit 3 still reads 1 is ignored and does not move the clear later.
- R10: With control bit 4 (clear-on-read) set, a read of the count register (address 1) returns the current count, and the counter is 0 after that edge.
- R11: While the timer is disabled (bit 0 = 0), writes of bits 1 to 4 are ignored.
- R12: Clearing bit 0 stops the counter, zeroes the count, drops any armed start and deasserts the DMA request.
- R13: The DMA request rises together with the update pulse and stays high until the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on the count register) |
| bus_addr | input | 1 | 0 = control register, 1 = count register |
| bus_wdata | input | 5 | Write data: bit0 enable, bit1 one-shot start, bit2 free-run start, bit3 counter clear, bit4 clear-on-read |
| bus_rdata | output | CNT_W | Read data for the addressed register (combinational) |
| trig_sel | input | 2 | `00` starts at once; any other value waits for the trigger |
| ext_trig | input | 1 | External trigger, sampled high at a clock edge |
| reload | input | CNT_W | Auto-reload compare value |
| count | output | CNT_W | Current counter value |
| update_evt | output | 1 | One-cycle pulse at each wrap |
| dma_req | output | 1 | Sticky update DMA request |

## Verification
The checker watches several rules on every cycle. The count only ever steps up by one or falls to zero. The update pulse is only seen with a zero count. The DMA request only rises together with an update. A disabled timer leaves the count at zero with no request. A pending clear holds for at least two cycles and leaves a zero count when it ends. The bench scenarios are needed for the rest: the exact cycle each start takes effect, stopping versus continuing after a mode switch, the three-edge clear delay and the ignored repeat clear, the value returned by a clearing read, arming and firing on the trigger, and writes dropped while disabled.

// File: rtl/tmr_pkg.sv
// Package: shared encodings for the one-shot/free-running timer.
// Assumes the control register is CTL_BITS wide and the count register
// is at least that wide.
package tmr_pkg;
    localparam int CTL_BITS = 5;
    localparam int CTL_EN   = 0;
    localparam int CTL_SGL  = 1;
    localparam int CTL_FRE  = 2;
    localparam int CTL_CLR  = 3;
    localparam int CTL_ROR  = 4;

    localparam logic       ADDR_CTL = 1'b0;
    localparam logic       ADDR_CNT = 1'b1;
    localparam logic [1:0] TRIG_SW  = 2'b00;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_FREERUN  = 1'b1
    } run_mode_e;
endpackage

// File: rtl/tmr_ctl_regs.sv
// Control register and start arbitration.
// Holds enable and clear-on-read, turns start writes into an immediate
// start pulse (software selector) or an armed request fired by the
// external trigger. Assumes wr_ctl is already decoded for the control
// address.
module tmr_ctl_regs
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctl,
    input  logic [CTL_BITS-1:0] wdata,
    input  logic [1:0]          trig_sel,
    input  logic                ext_trig,
    input  logic                crst_busy,
    output logic                en,
    output logic                ror,
    output logic                start_go,
    output run_mode_e           start_mode,
    output logic                arm_sgl,
    output logic                arm_fre,
    output logic                crst_launch
);
    logic      armed;
    run_mode_e armed_mode;
    logic      start_req;
    logic      sw_start;
    logic      trig_fire;
    run_mode_e req_mode;

    // Decode start requests and the trigger firing an armed start.
    always_comb begin
        start_req   = en && wr_ctl && (wdata[CTL_SGL] || wdata[CTL_FRE]);
        req_mode    = wdata[CTL_FRE] ? MODE_FREERUN : MODE_ONESHOT;
        sw_start    = start_req && (trig_sel == TRIG_SW);
        trig_fire   = en && armed && ext_trig;
        start_go    = sw_start || trig_fire;
        start_mode  = sw_start ? req_mode : armed_mode;
        crst_launch = en && wr_ctl && wdata[CTL_CLR] && !crst_busy;
        arm_sgl     = armed && (armed_mode == MODE_ONESHOT);
        arm_fre     = armed && (armed_mode == MODE_FREERUN);
    end

    // Register state: enable, clear-on-read and the single armed start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            ror        <= 1'b0;
            armed      <= 1'b0;
            armed_mode <= MODE_ONESHOT;
        end else begin
            if (wr_ctl) en <= wdata[CTL_EN];

            if (!en)         ror <= 1'b0;
            else if (wr_ctl) ror <= wdata[CTL_ROR];

            if (!en || (wr_ctl && !wdata[CTL_EN])) begin
                armed <= 1'b0;
            end else if (start_req && !sw_start) begin
                armed      <= 1'b1;
                armed_mode <= req_mode;
            end else if (trig_fire) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_clr_delay.sv
// Delayed counter-clear pipeline.
// Holds a pending clear for STAGES edges and pulses apply on the last.
// Assumes STAGES >= 2; a new launch is never accepted while busy
// (the control logic masks it).
module tmr_clr_delay #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic launch,
    output logic busy,
    output logic apply
);
    localparam int DW = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic [DW-1:0] dly;

    // The clear lands when the delay counter reaches its last stage.
    always_comb apply = busy && (dly == DW'(STAGES - 1));

    // Track the pending clear and its elapsed stages.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy <= 1'b0;
            dly  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            dly  <= '0;
        end else if (busy) begin
            if (apply) begin
                busy <= 1'b0;
                dly  <= '0;
            end else begin
                dly <= dly + DW'(1);
            end
        end
    end
endmodule

// File: rtl/tmr_core.sv
// Counter core: up-count, wrap at reload, update pulse, sticky DMA
// request and run/mode state. Assumes clear requests arrive as single
// cycle pulses and that a disabled timer holds everything at zero.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_go,
    input  run_mode_e        start_mode,
    input  logic [CNT_W-1:0] reload,
    input  logic             crst_apply,
    input  logic             rd_clear,
    output logic [CNT_W-1:0] count,
    output logic             update_evt,
    output logic             dma_req
);
    logic      running;
    run_mode_e mode;
    run_mode_e eff_mode;
    logic      clr;
    logic      wrap;

    // A mode written on the wrap edge already governs that wrap.
    always_comb begin
        clr      = crst_apply || rd_clear;
        wrap     = running && (count == reload) && !clr;
        eff_mode = start_go ? start_mode : mode;
    end

    // Count, wrap, pulse the update and hold the DMA request.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            count      <= '0;
            running    <= 1'b0;
            mode       <= MODE_ONESHOT;
            update_evt <= 1'b0;
            dma_req    <= 1'b0;
        end else begin
            update_evt <= 1'b0;
            if (start_go) mode <= start_mode;

            if (clr) begin
                count <= '0;
            end else if (wrap) begin
                count      <= '0;
                update_evt <= 1'b1;
                dma_req    <= 1'b1;
            end else if (running) begin
                count <= count + CNT_W'(1);
            end

            if (wrap && eff_mode == MODE_ONESHOT) running <= 1'b0;
            else if (start_go)                    running <= 1'b1;
        end
    end
endmodule

// File: rtl/tmr_mode_ctl.sv
// Top: one-shot / free-running timer controller.
// Decodes the two-register bus, wires control, delayed clear and counter
// core, and muxes read data. Assumes CNT_W >= CTL_BITS.
module tmr_mode_ctl
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                bus_addr,
    input  logic [CTL_BITS-1:0] bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    input  logic [1:0]          trig_sel,
    input  logic                ext_trig,
    input  logic [CNT_W-1:0]    reload,
    output logic [CNT_W-1:0]    count,
    output logic                update_evt,
    output logic                dma_req
);
    localparam int PAD_W = CNT_W - CTL_BITS;

    logic      wr_ctl;
    logic      rd_clear;
    logic      ctl_en;
    logic      ctl_ror;
    logic      start_go;
    run_mode_e start_mode;
    logic      arm_sgl;
    logic      arm_fre;
    logic      crst_launch;
    logic      crst_busy;
    logic      crst_apply;

    // Address decode for writes and for the clearing read.
    always_comb begin
        wr_ctl   = bus_wr && (bus_addr == ADDR_CTL);
        rd_clear = bus_rd && (bus_addr == ADDR_CNT) && ctl_ror;
    end

    tmr_ctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl      (wr_ctl),
        .wdata       (bus_wdata),
        .trig_sel    (trig_sel),
        .ext_trig    (ext_trig),
        .crst_busy   (crst_busy),
        .en          (ctl_en),
        .ror         (ctl_ror),
        .start_go    (start_go),
        .start_mode  (start_mode),
        .arm_sgl     (arm_sgl),
        .arm_fre     (arm_fre),
        .crst_launch (crst_launch)
    );

    tmr_clr_delay #(.STAGES(SYNC_STAGES)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_en),
        .launch (crst_launch),
        .busy   (crst_busy),
        .apply  (crst_apply)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctl_en),
        .start_go   (start_go),
        .start_mode (start_mode),
        .reload     (reload),
        .crst_apply (crst_apply),
        .rd_clear   (rd_clear),
        .count      (count),
        .update_evt (update_evt),
        .dma_req    (dma_req)
    );

    // Read mux: control shows live pending bits, count shows the counter.
    always_comb begin
        if (bus_addr == ADDR_CTL)
            bus_rdata = {{PAD_W{1'b0}}, ctl_ror, crst_busy, arm_fre, arm_sgl, ctl_en};
        else
            bus_rdata = count;
    end
endmodule

// File: rtl/tmr_mode_ctl_chk.sv
// Checker: cycle-level rules of the timer, bound to the top module.
// Assumes a synchronous active-low reset.
module tmr_mode_ctl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] count,
    input logic             update_evt,
    input logic             dma_req,
    input logic             crst_busy
);
    // R12: a disabled timer has zero count and no request on the next edge.
    a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0 && !dma_req));

    // R13: the request only rises together with an update pulse.
    a_r13_dma_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> update_evt);

    // R2: the update pulse is only seen with the count back at zero.
    a_r2_evt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |-> (count == '0));

    // R2: the count moves only by +1 or back to zero.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0));

    // R8: a pending clear lasts more than one cycle while enabled.
    a_r8_clear_span: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(crst_busy) && en) |=> crst_busy);

    // R8: when the pending clear ends the count is zero.
    a_r8_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crst_busy) |-> (count == '0));
endmodule

bind tmr_mode_ctl tmr_mode_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_en),
    .count      (count),
    .update_evt (update_evt),
    .dma_req    (dma_req),
    .crst_busy  (crst_busy)
);

// File: tb/tmr_mode_ctl_test.sv
`timescale 1ns/1ps
module tmr_mode_ctl_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic             bus_addr = 1'b1;
    logic [4:0]       bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic [1:0]       trig_sel = 2'b00;
    logic             ext_trig = 1'b0;
    logic [CNT_W-1:0] reload = 16'd5;
    logic [CNT_W-1:0] count;
    logic             update_evt;
    logic             dma_req;

    tmr_mode_ctl #(.CNT_W(CNT_W), .SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_sel(trig_sel), .ext_trig(ext_trig), .reload(reload),
        .count(count), .update_evt(update_evt), .dma_req(dma_req)
    );

    always #10 clk = ~clk;  // 50 MHz

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard item: kind 0 count, 1 update, 2 dma, 3 read data.
    typedef struct {
        int    due;
        int    kind;
        int    val;
        string tag;
    } exp_t;
    exp_t q[$];

    task automatic expect_at(input int due, input int kind, input int val, input string tag);
        q.push_back('{due, kind, val, tag});
    endtask

    // Monitor: pops every item due this cycle and compares it.
    always @(negedge clk) begin
        #2;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                int act;
                case (q[i].kind)
                    0:       act = int'(count);
                    1:       act = int'(update_evt);
                    2:       act = int'(dma_req);
                    default: act = int'(bus_rdata);
                endcase
                n_run++;
                if (act != q[i].val) begin
                    n_fail++;
                    $display("FAIL %s (kind %0d, cycle %0d): actual %0d expected %0d",
                             q[i].tag, q[i].kind, cyc, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic at(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] d);
        bus_addr = 1'b0; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic peek_ctl(input int val, input string tag);
        bus_addr = 1'b0;
        expect_at(cyc, 3, val, tag);
        @(negedge clk);
        bus_addr = 1'b1;
    endtask

    task automatic rd_cnt(input int val, input string tag);
        bus_addr = 1'b1; bus_rd = 1'b1;
        expect_at(cyc, 3, val, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t;
        int c;
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        t = cyc;
        expect_at(t, 0, 0, "R1 count");
        expect_at(t, 1, 0, "R1 update");
        expect_at(t, 2, 0, "R1 dma");
        peek_ctl(0, "R1 control");

        // R11: start/clear/clear-on-read writes while disabled are dropped
        wr(5'h1E);
        peek_ctl(0, "R11 control");
        t = cyc;
        expect_at(t + 2, 0, 0, "R11 count idle");
        at(t + 3);
        wr(5'h01);
        peek_ctl(1, "R11 enable only");

        // R3: software one-shot, reload 5
        t = cyc;
        wr(5'h03);
        for (int j = 0; j <= 6; j++)
            expect_at(t + 1 + j, 0, (j <= 5) ? j : 0, "R3 count");
        expect_at(t + 7, 1, 1, "R2 update at wrap");
        expect_at(t + 8, 1, 0, "R2 update one cycle");
        expect_at(t + 7, 2, 1, "R13 dma rises");
        expect_at(t + 10, 0, 0, "R3 halted");
        at(t + 12);

        // R4: software free-run, reload 3; then R6: one-shot mid-run
        reload = 16'd3;
        t = cyc;
        wr(5'h05);
        for (int j = 0; j <= 4; j++)
            expect_at(t + 1 + j, 0, j % 4, "R4 count");
        expect_at(t + 5, 1, 1, "R4 update");
        at(t + 5);
        wr(5'h03);
        expect_at(t + 6, 0, 1, "R6 keeps counting");
        expect_at(t + 7, 0, 2, "R6 count");
        expect_at(t + 8, 0, 3, "R6 count");
        expect_at(t + 9, 0, 0, "R6 wrap");
        expect_at(t + 9, 1, 1, "R6 update");
        expect_at(t + 11, 0, 0, "R6 stopped");
        expect_at(t + 13, 0, 0, "R6 stays stopped");
        at(t + 14);

        // R7: free-run written during a one-shot run
        t = cyc;
        wr(5'h03);
        at(t + 2);
        wr(5'h05);
        expect_at(t + 3, 0, 2, "R7 count");
        expect_at(t + 4, 0, 3, "R7 count");
        expect_at(t + 5, 0, 0, "R7 wrap");
        expect_at(t + 5, 1, 1, "R7 update");
        expect_at(t + 6, 0, 1, "R7 continues");
        expect_at(t + 7, 0, 2, "R7 continues");
        at(t + 8);

        // R12/R13: disable drops count and the held request
        t = cyc;
        expect_at(t, 2, 1, "R13 dma held");
        wr(5'h00);
        expect_at(t + 2, 0, 0, "R12 count");
        expect_at(t + 2, 2, 0, "R12 dma");
        at(t + 3);
        peek_ctl(0, "R12 control");

        // R8/R9: delayed clear and ignored repeat, reload 100
        reload = 16'd100;
        wr(5'h01);
        c = cyc;
        wr(5'h05);
        at(c + 10);
        expect_at(c + 11, 0, 10, "R8 before clear");
        wr(5'h09);
        peek_ctl(9, "R8 clear pending");
        wr(5'h09);
        expect_at(c + 13, 0, 12, "R8 still counting");
        expect_at(c + 14, 0, 0, "R8 cleared on third edge");
        expect_at(c + 15, 0, 1, "R8 counting resumes");
        expect_at(c + 16, 0, 2, "R9 repeat clear ignored");
        at(c + 16);
        peek_ctl(1, "R8 clear bit self-cleared");

        // R10: clearing read returns the count, then zero
        wr(5'h11);
        at(c + 22);
        expect_at(c + 23, 0, 0, "R10 cleared after read");
        expect_at(c + 24, 0, 1, "R10 counts again");
        rd_cnt(8, "R10 read value");
        at(c + 25);

        // R5: triggered one-shot, reload 2, selector 01
        wr(5'h00);
        reload = 16'd2;
        trig_sel = 2'b01;
        wr(5'h01);
        t = cyc;
        wr(5'h03);
        at(t + 2);
        peek_ctl(3, "R5 armed one-shot");
        expect_at(t + 4, 0, 0, "R5 waits for trigger");
        at(t + 5);
        g = cyc;
        expect_at(g + 1, 0, 0, "R5 started");
        expect_at(g + 2, 0, 1, "R5 count");
        expect_at(g + 3, 0, 2, "R5 count");
        expect_at(g + 4, 0, 0, "R5 wrap");
        expect_at(g + 4, 1, 1, "R5 update");
        expect_at(g + 6, 0, 0, "R5 one-shot halted");
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        peek_ctl(1, "R5 armed bit consumed");
        at(g + 8);

        finish_run();
    end
endmodule